// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Decoder

This block is the register front end of one 8-line interrupt controller. It has a byte-wide register port with a single address bit. Writes to that port are sorted into three kinds. An initialization-start word launches a short configuration sequence: vector base, an unused cascade word, and an optional mode word. An operation-control word sets read selection and special mask and arms a poll. A priority command word produces one-cycle command strobes for the priority resolver. In normal operation, data writes at address 1 load the interrupt mask.

Reads return the request register, the in-service register or the mask. When a poll has been armed, the next read instead returns the number of the highest pending line and tells the resolver to retire that line. The priority logic is outside this block. The block receives the request and in-service vectors and the resolver's "pending line" result, and it drives the mask, vector base, mode bits and strobes that the resolver uses.

The register port is a plain strobe interface with no back-pressure. Every `wr_en` or `rd_en` cycle is accepted, so there is no ready signal, and a caller may issue one access per clock. Read data comes back with `rd_valid` one cycle later and cannot be stalled. Results and strobes are registered, so a write or read in cycle N takes effect in cycle N+1.

Top module: `intc_cmd_decoder`

## Requirements
- R1: After reset the mask, vector base and all mode bits are 0, the sequencer is in normal operation, poll is disarmed, no strobe is active, and an address-0 read returns the request vector.
- R2: A write at address 0 with data bit 4 set starts initialization. One cycle later, `init_stb` pulses and the mask, special mask and read-select bit are 0. If data bit 0 was 0, fully nested mode and auto end-of-interrupt are also cleared. A start word received in any sequencer state restarts the sequence.
- R3: The first address-1 write after a start word sets `vec_base` to the data with bits 2:0 forced to 0. The second address-1 write is consumed without effect. If the start word had bit 0 clear, the next address-1 write loads the mask.
- R4: When the start word had bit 0 set, the third address-1 write loads fully nested mode from data bit 4 and auto end-of-interrupt from data bit 1. Operation then returns to normal.
- R5: In normal operation, an address-1 write loads the mask with the data, visible on `mask` one cycle later.
- R6: An address-0 write with bit 4 clear and bit 3 set is an operation-control word. Bit 2 set arms poll. Bit 1 set loads read-select from bit 0, and bit 1 clear leaves read-select unchanged. Bit 6 set loads special mask from bit 5, and bit 6 clear leaves special mask unchanged.
- R7: An address-0 write with bits 4 and 3 clear is a priority command selected by data bits 7:5. Code 1 pulses `eoi_ns_stb`, code 5 `eoi_rot_ns_stb`, code 3 `eoi_spec_stb`, code 7 `eoi_rot_spec_stb`, and code 6 `set_prio_stb`. The pulse lasts one cycle, in the cycle after the write, and `cmd_line` then carries data bits 2:0. Code 2 produces no strobe.
- R8: Priority-command codes 0 and 4 set `rot_on_aeoi` to data bit 7 and produce no strobe.
- R9: A read pulses `rd_valid` one cycle later. If poll is not armed, `rd_data` is the in-service vector (address 0, read-select 1), the request vector (address 0, read-select 0) or the mask (address 1).
- R10: With poll armed and `pend_valid` high, a read of either address returns `pend_line` in `rd_data` bits 2:0, with the upper bits 0. In the same cycle, `poll_ack_stb` pulses with `poll_line` equal to that line. Poll is then disarmed, so the next read is an ordinary register read.
- R11: With poll armed and `pend_valid` low, a read returns 7, gives no `poll_ack_stb`, and disarms poll.
- R12: At most one priority-command strobe is active in any cycle, and back-to-back command writes give strobes in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Request vector from resolver |
| isr_in | input | 8 | In-service vector from resolver |
| pend_valid | input | 1 | Resolver has a line to grant |
| pend_line | input | 3 | Line the resolver would grant |
| mask | output | 8 | Interrupt mask register |
| vec_base | output | 8 | Vector base, bits 2:0 zero |
| fully_nested | output | 1 | Fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-interrupt |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode |
| init_stb | output | 1 | Initialization started (clear rotation base) |
| eoi_ns_stb | output | 1 | Non-specific end-of-interrupt |
| eoi_rot_ns_stb | output | 1 | Rotating non-specific end-of-interrupt |
| eoi_spec_stb | output | 1 | Specific end-of-interrupt |
| eoi_rot_spec_stb | output | 1 | Rotating specific end-of-interrupt |
| set_prio_stb | output | 1 | Set lowest-priority line |
| cmd_line | output | 3 | Line operand of the last priority command |
| poll_ack_stb | output | 1 | Poll read granted a line |
| poll_line | output | 3 | Line granted by the poll read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
Every result in this block is due exactly one clock after the access that causes it. This covers register and mode updates, `init_stb`, command strobes, `rd_valid` with `rd_data`, and `poll_ack_stb`. The bench's reference model advances at the same rising edge as the design, using the inputs that were held stable across that edge. All outputs are compared at the following falling edge, so every result is checked in its due cycle and in no other. Read data and the poll line are compared only in cycles where the model expects `rd_valid` or `poll_ack_stb`. This lets a strobe that arrives a cycle early or late show up as a mismatch on the strobe itself.

// File: rtl/icd_pkg.sv
package icd_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_SKIP = 2'd2,
    SEQ_MODE = 2'd3
  } seq_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF  = 3'd0,
    OP_NS_EOI   = 3'd1,
    OP_NONE     = 3'd2,
    OP_SP_EOI   = 3'd3,
    OP_ROT_ON   = 3'd4,
    OP_RNS_EOI  = 3'd5,
    OP_SET_PRI  = 3'd6,
    OP_RSP_EOI  = 3'd7
  } prio_op_e;

  typedef struct packed {
    logic start;
    logic opctl;
    logic prio;
    logic data;
  } wr_kind_t;

  localparam int B_START   = 4;
  localparam int B_OPCTL   = 3;
  localparam int B_NEED4   = 0;
  localparam int B_POLL    = 2;
  localparam int B_RSEL_EN = 1;
  localparam int B_RSEL    = 0;
  localparam int B_SMM_EN  = 6;
  localparam int B_SMM     = 5;
  localparam int B_FNM     = 4;
  localparam int B_AEOI    = 1;
endpackage

// File: rtl/icd_word_class.sv
module icd_word_class
  import icd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output wr_kind_t          kind
);
  always_comb begin
    kind       = '0;
    kind.data  = wr_en && addr;
    kind.start = wr_en && !addr && wdata[B_START];
    kind.opctl = wr_en && !addr && !wdata[B_START] && wdata[B_OPCTL];
    kind.prio  = wr_en && !addr && !wdata[B_START] && !wdata[B_OPCTL];
  end
endmodule

// File: rtl/icd_init_seq.sv
module icd_init_seq
  import icd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wr_kind_t          kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] vec_base,
  output logic              fully_nested,
  output logic              auto_eoi,
  output logic              init_stb
);
  localparam int LW = $clog2(N_LINES);
  localparam logic [DATA_W-1:0] BASE_KEEP = {{(DATA_W-LW){1'b1}}, {LW{1'b0}}};

  seq_e state_q;
  logic need4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= SEQ_RUN;
      need4_q      <= 1'b0;
      mask         <= '0;
      vec_base     <= '0;
      fully_nested <= 1'b0;
      auto_eoi     <= 1'b0;
      init_stb     <= 1'b0;
    end else begin
      init_stb <= kind.start;
      if (kind.start) begin
        state_q <= SEQ_BASE;
        need4_q <= wdata[B_NEED4];
        mask    <= '0;
        if (!wdata[B_NEED4]) begin
          fully_nested <= 1'b0;
          auto_eoi     <= 1'b0;
        end
      end else if (kind.data) begin
        unique case (state_q)
          SEQ_RUN:  mask <= wdata;
          SEQ_BASE: begin
            vec_base <= wdata & BASE_KEEP;
            state_q  <= SEQ_SKIP;
          end
          SEQ_SKIP: state_q <= need4_q ? SEQ_MODE : SEQ_RUN;
          SEQ_MODE: begin
            fully_nested <= wdata[B_FNM];
            auto_eoi     <= wdata[B_AEOI];
            state_q      <= SEQ_RUN;
          end
          default:  state_q <= SEQ_RUN;
        endcase
      end
    end
  end

  // R2
  init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |-> (mask == '0));

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> ($stable(fully_nested) && $stable(auto_eoi)));

  // R3
  base_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_base & ~BASE_KEEP) == '0);
endmodule

// File: rtl/icd_cmd_decode.sv
module icd_cmd_decode
  import icd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  wr_kind_t                   kind,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       poll_taken,
  output logic                       rot_on_aeoi,
  output logic                       special_mask,
  output logic                       read_isr,
  output logic                       poll_armed,
  output logic                       eoi_ns_stb,
  output logic                       eoi_rot_ns_stb,
  output logic                       eoi_spec_stb,
  output logic                       eoi_rot_spec_stb,
  output logic                       set_prio_stb,
  output logic [$clog2(N_LINES)-1:0] cmd_line
);
  localparam int LW = $clog2(N_LINES);

  prio_op_e op;
  assign op = prio_op_e'(wdata[DATA_W-1 -: 3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rot_on_aeoi      <= 1'b0;
      special_mask     <= 1'b0;
      read_isr         <= 1'b0;
      poll_armed       <= 1'b0;
      eoi_ns_stb       <= 1'b0;
      eoi_rot_ns_stb   <= 1'b0;
      eoi_spec_stb     <= 1'b0;
      eoi_rot_spec_stb <= 1'b0;
      set_prio_stb     <= 1'b0;
      cmd_line         <= '0;
    end else begin
      eoi_ns_stb       <= kind.prio && (op == OP_NS_EOI);
      eoi_rot_ns_stb   <= kind.prio && (op == OP_RNS_EOI);
      eoi_spec_stb     <= kind.prio && (op == OP_SP_EOI);
      eoi_rot_spec_stb <= kind.prio && (op == OP_RSP_EOI);
      set_prio_stb     <= kind.prio && (op == OP_SET_PRI);
      if (kind.prio) begin
        cmd_line <= wdata[LW-1:0];
        if (op == OP_ROT_OFF || op == OP_ROT_ON)
          rot_on_aeoi <= wdata[DATA_W-1];
      end
      if (poll_taken) poll_armed <= 1'b0;
      if (kind.start) begin
        special_mask <= 1'b0;
        read_isr     <= 1'b0;
      end else if (kind.opctl) begin
        if (wdata[B_POLL])    poll_armed   <= 1'b1;
        if (wdata[B_RSEL_EN]) read_isr     <= wdata[B_RSEL];
        if (wdata[B_SMM_EN])  special_mask <= wdata[B_SMM];
      end
    end
  end

  // R12
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoi_ns_stb, eoi_rot_ns_stb, eoi_spec_stb, eoi_rot_spec_stb, set_prio_stb}));

  // R7
  stb_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns_stb || eoi_rot_ns_stb || eoi_spec_stb || eoi_rot_spec_stb || set_prio_stb)
    |-> $past(wr_en));
endmodule

// File: rtl/icd_read_port.sv
module icd_read_port
  import icd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic                       addr,
  input  logic                       poll_armed,
  input  logic                       read_isr,
  input  logic [DATA_W-1:0]          mask,
  input  logic [N_LINES-1:0]         irr_in,
  input  logic [N_LINES-1:0]         isr_in,
  input  logic                       pend_valid,
  input  logic [$clog2(N_LINES)-1:0] pend_line,
  output logic                       poll_taken,
  output logic                       rd_valid,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       poll_ack_stb,
  output logic [$clog2(N_LINES)-1:0] poll_line
);
  localparam int LW = $clog2(N_LINES);
  localparam logic [LW-1:0] IDLE_LINE = LW'(N_LINES - 1);

  logic [DATA_W-1:0] reg_sel;

  assign poll_taken = rd_en && poll_armed;

  always_comb begin
    if (addr)          reg_sel = mask;
    else if (read_isr) reg_sel = DATA_W'(isr_in);
    else               reg_sel = DATA_W'(irr_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      poll_ack_stb <= 1'b0;
      poll_line    <= '0;
    end else begin
      rd_valid     <= rd_en;
      poll_ack_stb <= poll_taken && pend_valid;
      if (poll_taken) begin
        rd_data <= DATA_W'(pend_valid ? pend_line : IDLE_LINE);
        if (pend_valid) poll_line <= pend_line;
      end else if (rd_en) begin
        rd_data <= reg_sel;
      end
    end
  end

  // R9
  rd_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));

  // R10
  ack_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack_stb |-> (rd_valid && rd_data == DATA_W'(poll_line)));

  // R11
  ack_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack_stb |-> $past(pend_valid));
endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
  import icd_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8,
  localparam int LW     = $clog2(N_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_LINES-1:0] irr_in,
  input  logic [N_LINES-1:0] isr_in,
  input  logic              pend_valid,
  input  logic [LW-1:0]     pend_line,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] vec_base,
  output logic              fully_nested,
  output logic              auto_eoi,
  output logic              rot_on_aeoi,
  output logic              special_mask,
  output logic              init_stb,
  output logic              eoi_ns_stb,
  output logic              eoi_rot_ns_stb,
  output logic              eoi_spec_stb,
  output logic              eoi_rot_spec_stb,
  output logic              set_prio_stb,
  output logic [LW-1:0]     cmd_line,
  output logic              poll_ack_stb,
  output logic [LW-1:0]     poll_line,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  wr_kind_t kind;
  logic     read_isr;
  logic     poll_armed;
  logic     poll_taken;

  icd_word_class #(.DATA_W(DATA_W)) u_class (
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .kind  (kind)
  );

  icd_init_seq #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .kind         (kind),
    .wdata        (wdata),
    .mask         (mask),
    .vec_base     (vec_base),
    .fully_nested (fully_nested),
    .auto_eoi     (auto_eoi),
    .init_stb     (init_stb)
  );

  icd_cmd_decode #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_cmd (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .kind             (kind),
    .wdata            (wdata),
    .poll_taken       (poll_taken),
    .rot_on_aeoi      (rot_on_aeoi),
    .special_mask     (special_mask),
    .read_isr         (read_isr),
    .poll_armed       (poll_armed),
    .eoi_ns_stb       (eoi_ns_stb),
    .eoi_rot_ns_stb   (eoi_rot_ns_stb),
    .eoi_spec_stb     (eoi_spec_stb),
    .eoi_rot_spec_stb (eoi_rot_spec_stb),
    .set_prio_stb     (set_prio_stb),
    .cmd_line         (cmd_line)
  );

  icd_read_port #(.DATA_W(DATA_W), .N_LINES(N_LINES)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .addr         (addr),
    .poll_armed   (poll_armed),
    .read_isr     (read_isr),
    .mask         (mask),
    .irr_in       (irr_in),
    .isr_in       (isr_in),
    .pend_valid   (pend_valid),
    .pend_line    (pend_line),
    .poll_taken   (poll_taken),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .poll_ack_stb (poll_ack_stb),
    .poll_line    (poll_line)
  );

  // R1
  idle_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> !(init_stb || eoi_ns_stb || set_prio_stb));
endmodule

// File: tb/intc_cmd_decoder_tb.sv
module intc_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
  logic       pend_valid = 1'b0;
  logic [2:0] pend_line = '0;

  logic [7:0] mask, vec_base, rd_data;
  logic       fully_nested, auto_eoi, rot_on_aeoi, special_mask, init_stb;
  logic       eoi_ns_stb, eoi_rot_ns_stb, eoi_spec_stb, eoi_rot_spec_stb, set_prio_stb;
  logic [2:0] cmd_line, poll_line;
  logic       poll_ack_stb, rd_valid;

  always #2.5 clk = ~clk;

  intc_cmd_decoder dut_i (.*);

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_state = 0;
  bit m_need4 = 0, m_fnm = 0, m_aeoi = 0, m_rot = 0, m_smm = 0, m_rsel = 0, m_poll = 0;
  int m_mask = 0, m_vec = 0, e_line = 0, e_pline = 0, e_rd = 0;
  bit e_init = 0, e_rdv = 0, e_pack = 0;
  bit e_stb[5] = '{0, 0, 0, 0, 0};

  task automatic cmp(string sig, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, sig, act, exp);
    end
  endtask

  task automatic model_step();
    int op;
    e_init = 0; e_rdv = 0; e_pack = 0;
    foreach (e_stb[i]) e_stb[i] = 0;
    if (!rst_n) begin
      m_state = 0; m_need4 = 0; m_fnm = 0; m_aeoi = 0; m_rot = 0; m_smm = 0;
      m_rsel = 0; m_poll = 0; m_mask = 0; m_vec = 0; e_line = 0; e_pline = 0; e_rd = 0;
      return;
    end
    if (rd_en) begin
      e_rdv = 1;
      if (m_poll) begin
        if (pend_valid) begin e_rd = pend_line; e_pack = 1; e_pline = pend_line; end
        else e_rd = 7;
        m_poll = 0;
      end else if (addr) e_rd = m_mask;
      else e_rd = m_rsel ? isr_in : irr_in;
    end
    if (wr_en) begin
      if (!addr && wdata[4]) begin
        e_init = 1; m_state = 1; m_need4 = wdata[0]; m_mask = 0; m_smm = 0; m_rsel = 0;
        if (!wdata[0]) begin m_fnm = 0; m_aeoi = 0; end
      end else if (!addr && wdata[3]) begin
        if (wdata[2]) m_poll = 1;
        if (wdata[1]) m_rsel = wdata[0];
        if (wdata[6]) m_smm = wdata[5];
      end else if (!addr) begin
        op = wdata[7:5];
        e_line = wdata[2:0];
        case (op)
          0, 4: m_rot = wdata[7];
          1: e_stb[0] = 1;
          5: e_stb[1] = 1;
          3: e_stb[2] = 1;
          7: e_stb[3] = 1;
          6: e_stb[4] = 1;
          default: ;
        endcase
      end else begin
        case (m_state)
          0: m_mask = wdata;
          1: begin m_vec = wdata & 8'hF8; m_state = 2; end
          2: m_state = m_need4 ? 3 : 0;
          default: begin m_fnm = wdata[4]; m_aeoi = wdata[1]; m_state = 0; end
        endcase
      end
    end
  endtask

  task automatic compare_all();
    cmp("mask", mask, m_mask);
    cmp("vec_base", vec_base, m_vec);
    cmp("fully_nested", fully_nested, m_fnm);
    cmp("auto_eoi", auto_eoi, m_aeoi);
    cmp("rot_on_aeoi", rot_on_aeoi, m_rot);
    cmp("special_mask", special_mask, m_smm);
    cmp("init_stb", init_stb, e_init);
    cmp("eoi_ns_stb", eoi_ns_stb, e_stb[0]);
    cmp("eoi_rot_ns_stb", eoi_rot_ns_stb, e_stb[1]);
    cmp("eoi_spec_stb", eoi_spec_stb, e_stb[2]);
    cmp("eoi_rot_spec_stb", eoi_rot_spec_stb, e_stb[3]);
    cmp("set_prio_stb", set_prio_stb, e_stb[4]);
    cmp("cmd_line", cmd_line, e_line);
    cmp("rd_valid", rd_valid, e_rdv);
    cmp("poll_ack_stb", poll_ack_stb, e_pack);
    if (e_rdv) cmp("rd_data", rd_data, e_rd);
    if (e_pack) cmp("poll_line", poll_line, e_pline);
  endtask

  // one clock: inputs already driven; model advances at edge, compare at falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(bit a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; tick();
  endtask

  task automatic rd(bit a);
    rd_en = 1; addr = a; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    // R1: reset state, default read returns request vector
    cur_req = "R1";
    tick();
    irr_in = 8'h5A; isr_in = 8'hC3;
    rd(0); tick();
    // R2 / R3 / R4: full four-word sequence
    cur_req = "R2";
    wr(0, 8'h11);
    cur_req = "R3";
    wr(1, 8'h47);
    wr(1, 8'hFF);
    cur_req = "R4";
    wr(1, 8'h12);
    // R5: mask load in normal operation, then readback
    cur_req = "R5";
    wr(1, 8'hA5);
    cur_req = "R9";
    rd(1); tick();
    // R2: restart without fourth word clears modes and mask
    cur_req = "R2";
    wr(0, 8'h10);
    cur_req = "R3";
    wr(1, 8'h8E);
    wr(1, 8'h00);
    wr(1, 8'h3C);
    rd(1);
    // R2: restart mid-sequence
    cur_req = "R2";
    wr(0, 8'h11);
    wr(1, 8'h20);
    wr(0, 8'h10);
    wr(1, 8'hB8);
    wr(1, 8'h00);
    wr(1, 8'h0F);
    // R6: operation-control word
    cur_req = "R6";
    wr(0, 8'h0B);
    rd(0);
    wr(0, 8'h09);
    rd(0);
    wr(0, 8'h0A);
    rd(0);
    wr(0, 8'h68);
    wr(0, 8'h28);
    wr(0, 8'h48);
    // R7: priority commands, code 2 silent
    cur_req = "R7";
    wr(0, 8'h20); tick();
    wr(0, 8'hA0); tick();
    wr(0, 8'h63); tick();
    wr(0, 8'hE5); tick();
    wr(0, 8'hC2); tick();
    wr(0, 8'h46); tick();
    // R8: rotate-on-auto-EOI
    cur_req = "R8";
    wr(0, 8'h80);
    wr(0, 8'h00);
    wr(0, 8'h84);
    // R12: back-to-back commands
    cur_req = "R12";
    wr(0, 8'h21);
    wr(0, 8'hC7);
    wr(0, 8'h64);
    wr(0, 8'hE2);
    tick();
    // R10: poll with pending line
    cur_req = "R10";
    wr(0, 8'h0C);
    pend_valid = 1; pend_line = 3'd5;
    rd(1);
    rd(1);
    wr(0, 8'h0C);
    pend_line = 3'd0;
    rd(0);
    rd(0);
    // R11: poll with nothing pending
    cur_req = "R11";
    wr(0, 8'h0C);
    pend_valid = 0;
    rd(0);
    rd(0);
    tick();
    finish_run();
  end
endmodule